// File: doc/BRIEF.md
# Strobed Input Port Pair with Handshake Flags

This block handles the input side of two 8-bit peripheral ports, called A and B, in a programmable parallel interface. A peripheral places a byte on its port and pulls that port's active-low strobe low. The byte is captured, and a buffer-full flag goes high to tell the peripheral that the byte was taken. Once the strobe is released, an interrupt request is raised if the port's interrupt enable is set. The CPU then reads the port. The read clears the interrupt when it starts and clears the buffer-full flag when it ends.

Every asynchronous input (port data, strobes, the read strobe and the port selects) passes through a synchroniser of `SYNC_STAGES` flops before it is used. Edges are found by comparing each sampled signal with its value on the previous cycle. The CPU changes the two interrupt enables with single-bit set/reset commands on the handshake port. The handshake flags leave the block on an 8-bit handshake-port vector, which has a fixed pin layout and a fixed direction mask.

Top module: `ppi_strobed_input`

## Requirements
- R1: While a port's synchronised strobe is low, the byte on that port is copied into its data output. While the strobe is high, the data output holds its value whatever the port lines do.
- R2: A port's buffer-full flag goes to 1 while its strobe is low.
- R3: A port's buffer-full flag returns to 0 when a CPU read of that port ends. A read is active while `rd_n_i` is 0 and the port's select is 1. A read of the other port leaves this port's flags unchanged.
- R4: A port's interrupt request becomes 1 when four conditions hold together: its strobe is high, its buffer is full, its enable is 1, and no read of it is active.
- R5: A port's interrupt request drops to 0 when a CPU read of that port begins, and stays 0 while the read is active.
- R6: While a port's enable is 0, its interrupt request is 0. Clearing the enable while a request is pending withdraws the request.
- R7: A set/reset command with bit number 4 writes the port A enable, and bit number 2 writes the port B enable. Commands with any other bit number leave both enables unchanged. Both enables are 0 after reset.
- R8: Handshake-port vector `pc_o` layout: bit 3 = A interrupt, bit 5 = A buffer full, bit 0 = B interrupt, bit 1 = B buffer full. All other bits are 0. `pc_oe_o` is 8'h2B: the flag pins are outputs, and the strobe pins (bit 4 for A, bit 2 for B) are inputs.
- R9: A strobe that arrives while the buffer is already full overwrites the data and leaves buffer-full at 1.
- R10: After reset, both data outputs are 0 and `pc_o` is 0.
- R11: A strobe that goes low before a clock edge shows as buffer-full exactly `SYNC_STAGES`+1 rising edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pa_i | input | DATA_W | Port A peripheral data |
| pb_i | input | DATA_W | Port B peripheral data |
| stb_a_n_i | input | 1 | Port A strobe, active low |
| stb_b_n_i | input | 1 | Port B strobe, active low |
| rd_n_i | input | 1 | CPU read strobe, active low |
| sel_a_i | input | 1 | CPU read targets port A |
| sel_b_i | input | 1 | CPU read targets port B |
| bsr_we_i | input | 1 | Bit set/reset command valid (one cycle) |
| bsr_bit_i | input | 3 | Bit number of the set/reset command |
| bsr_val_i | input | 1 | Value written by the command |
| pa_data_o | output | DATA_W | Latched port A byte |
| pb_data_o | output | DATA_W | Latched port B byte |
| pc_o | output | 8 | Handshake-port flag values |
| pc_oe_o | output | 8 | Handshake-port direction mask, 1 = output |

## Verification
The bench builds the block with `DATA_W` = 8 and `SYNC_STAGES` = 3 instead of the default of 2. The deeper synchroniser shows that the exact-latency check of R11 follows the parameter rather than a fixed count. It also makes every handshake step span several cycles, so the mid-read state can be sampled while the read is still active. The random mix of overlapping strobes on both ports, single-port and dual-port reads, and set/reset commands on every bit number checks that the two ports stay independent.

// File: rtl/ppi_strobe_pkg.sv
package ppi_strobe_pkg;
    localparam int PC_W      = 8;
    localparam int PC_IRQ_B  = 0;
    localparam int PC_FULL_B = 1;
    localparam int PC_STB_B  = 2;
    localparam int PC_IRQ_A  = 3;
    localparam int PC_STB_A  = 4;
    localparam int PC_FULL_A = 5;
    localparam logic [2:0] INTE_A_BIT = 3'd4;
    localparam logic [2:0] INTE_B_BIT = 3'd2;
    localparam logic [PC_W-1:0] PC_OE_MASK =
        (8'd1 << PC_IRQ_B) | (8'd1 << PC_FULL_B) | (8'd1 << PC_IRQ_A) | (8'd1 << PC_FULL_A);
endpackage

// File: rtl/ppi_sync_pipe.sv
module ppi_sync_pipe #(
    parameter int         W         = 10,
    parameter int         STAGES    = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_d[g];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/strobe_in_chan.sv
module strobe_in_chan #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pdata_i,
    input  logic              stb_n_i,
    input  logic              rd_act_i,
    input  logic              inte_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              irq_o
);
    localparam int SW = DATA_W + 2;
    localparam logic [SW-1:0] SYNC_RST = {{DATA_W{1'b0}}, 1'b1, 1'b0};

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              irq;
        logic              rd_prev;
    } chan_st_t;

    logic [SW-1:0]     sync_out;
    logic [DATA_W-1:0] sdata_s;
    logic              stb_low_s;
    logic              rd_act_s;
    logic              rd_begin;
    logic              rd_end;
    chan_st_t          st_d, st_q;

    ppi_sync_pipe #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({pdata_i, stb_n_i, rd_act_i}),
        .dout (sync_out)
    );

    assign sdata_s   = sync_out[SW-1:2];
    assign stb_low_s = ~sync_out[1];
    assign rd_act_s  = sync_out[0];
    assign rd_begin  = rd_act_s & ~st_q.rd_prev;
    assign rd_end    = ~rd_act_s & st_q.rd_prev;

    always_comb begin
        st_d         = st_q;
        st_d.rd_prev = rd_act_s;
        if (stb_low_s) begin
            st_d.data = sdata_s;
            st_d.full = 1'b1;
        end else if (rd_end) begin
            st_d.full = 1'b0;
        end
        if (rd_begin || rd_act_s || !inte_i) begin
            st_d.irq = 1'b0;
        end else if (!stb_low_s && st_q.full && !rd_end) begin
            st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o = st_q.data;
    assign full_o = st_q.full;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/ppi_strobed_input.sv
module ppi_strobed_input
    import ppi_strobe_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pa_i,
    input  logic [DATA_W-1:0] pb_i,
    input  logic              stb_a_n_i,
    input  logic              stb_b_n_i,
    input  logic              rd_n_i,
    input  logic              sel_a_i,
    input  logic              sel_b_i,
    input  logic              bsr_we_i,
    input  logic [2:0]        bsr_bit_i,
    input  logic              bsr_val_i,
    output logic [DATA_W-1:0] pa_data_o,
    output logic [DATA_W-1:0] pb_data_o,
    output logic [PC_W-1:0]   pc_o,
    output logic [PC_W-1:0]   pc_oe_o
);
    localparam int NCH = 2;

    typedef struct packed {
        logic inte_a;
        logic inte_b;
    } en_st_t;

    en_st_t en_d, en_q;

    logic [NCH-1:0][DATA_W-1:0] ch_pdata;
    logic [NCH-1:0][DATA_W-1:0] ch_data;
    logic [NCH-1:0]             ch_stb_n;
    logic [NCH-1:0]             ch_sel;
    logic [NCH-1:0]             ch_inte;
    logic [NCH-1:0]             ch_full;
    logic [NCH-1:0]             ch_irq;

    always_comb begin
        en_d = en_q;
        if (bsr_we_i && bsr_bit_i == INTE_A_BIT) en_d.inte_a = bsr_val_i;
        if (bsr_we_i && bsr_bit_i == INTE_B_BIT) en_d.inte_b = bsr_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign ch_pdata = {pb_i, pa_i};
    assign ch_stb_n = {stb_b_n_i, stb_a_n_i};
    assign ch_sel   = {sel_b_i, sel_a_i};
    assign ch_inte  = {en_q.inte_b, en_q.inte_a};

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        strobe_in_chan #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .pdata_i (ch_pdata[c]),
            .stb_n_i (ch_stb_n[c]),
            .rd_act_i(~rd_n_i & ch_sel[c]),
            .inte_i  (ch_inte[c]),
            .data_o  (ch_data[c]),
            .full_o  (ch_full[c]),
            .irq_o   (ch_irq[c])
        );
    end

    always_comb begin
        pc_o            = '0;
        pc_o[PC_IRQ_A]  = ch_irq[0];
        pc_o[PC_FULL_A] = ch_full[0];
        pc_o[PC_IRQ_B]  = ch_irq[1];
        pc_o[PC_FULL_B] = ch_full[1];
    end

    assign pc_oe_o   = PC_OE_MASK;
    assign pa_data_o = ch_data[0];
    assign pb_data_o = ch_data[1];
endmodule

// File: rtl/strobe_in_chan_chk.sv
module strobe_in_chan_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stb_low_s,
    input logic              rd_act_s,
    input logic [DATA_W-1:0] sdata_s,
    input logic              inte_i,
    input logic [DATA_W-1:0] data_o,
    input logic              full_o,
    input logic              irq_o
);
    logic rd_seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_seen_q <= 1'b0;
        else        rd_seen_q <= rd_act_s;
    end

    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
        stb_low_s |=> data_o == $past(sdata_s));
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_low_s |=> $stable(data_o));
    a_r2_full_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        stb_low_s |=> full_o);
    a_r3_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_seen_q && !rd_act_s && !stb_low_s) |=> !full_o);
    a_r4_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(full_o) && $past(inte_i)));
    a_r5_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        rd_act_s |=> !irq_o);
    a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !inte_i |=> !irq_o);
endmodule

bind strobe_in_chan strobe_in_chan_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb_low_s(stb_low_s),
    .rd_act_s (rd_act_s),
    .sdata_s  (sdata_s),
    .inte_i   (inte_i),
    .data_o   (data_o),
    .full_o   (full_o),
    .irq_o    (irq_o)
);

// File: tb/ppi_strobed_input_bench.sv
`timescale 1ns/1ps
module ppi_strobed_input_bench;
    localparam int DW   = 8;
    localparam int SYNC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DW-1:0] pa_i = '0, pb_i = '0;
    logic stb_a_n_i = 1'b1, stb_b_n_i = 1'b1, rd_n_i = 1'b1;
    logic sel_a_i = 1'b0, sel_b_i = 1'b0;
    logic bsr_we_i = 1'b0, bsr_val_i = 1'b0;
    logic [2:0] bsr_bit_i = '0;
    logic [DW-1:0] pa_data_o, pb_data_o;
    logic [7:0] pc_o, pc_oe_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] e_data [2];
    logic          e_full [2];
    logic          e_irq  [2];
    logic          e_inte [2];

    always #4 clk = ~clk;

    ppi_strobed_input #(.DATA_W(DW), .SYNC_STAGES(SYNC)) u_ppi_strobed_input (
        .clk(clk), .rst_n(rst_n), .pa_i(pa_i), .pb_i(pb_i),
        .stb_a_n_i(stb_a_n_i), .stb_b_n_i(stb_b_n_i), .rd_n_i(rd_n_i),
        .sel_a_i(sel_a_i), .sel_b_i(sel_b_i), .bsr_we_i(bsr_we_i),
        .bsr_bit_i(bsr_bit_i), .bsr_val_i(bsr_val_i),
        .pa_data_o(pa_data_o), .pb_data_o(pb_data_o),
        .pc_o(pc_o), .pc_oe_o(pc_oe_o)
    );

    function automatic logic [7:0] exp_pc();
        logic [7:0] r = '0;
        r[3] = e_irq[0];
        r[5] = e_full[0];
        r[0] = e_irq[1];
        r[1] = e_full[1];
        return r;
    endfunction

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        cmp({tag, " R1 port A data"}, 32'(pa_data_o), 32'(e_data[0]));
        cmp({tag, " R1 port B data"}, 32'(pb_data_o), 32'(e_data[1]));
        cmp({tag, " R8 pc flags"}, 32'(pc_o), 32'(exp_pc()));
        cmp({tag, " R8 pc direction"}, 32'(pc_oe_o), 32'h2B);
    endtask

    task automatic settle();
        repeat (SYNC + 3) @(negedge clk);
    endtask

    task automatic idle_irq();
        for (int c = 0; c < 2; c++) e_irq[c] = e_full[c] & e_inte[c];
    endtask

    task automatic do_strobe(input bit ea, input bit eb, input logic [DW-1:0] va,
                             input logic [DW-1:0] vb, input string tag);
        @(negedge clk);
        if (ea) begin pa_i = va; stb_a_n_i = 1'b0; end
        if (eb) begin pb_i = vb; stb_b_n_i = 1'b0; end
        repeat (2) @(negedge clk);
        stb_a_n_i = 1'b1;
        stb_b_n_i = 1'b1;
        pa_i = ~va;
        pb_i = ~vb;
        if (ea) begin e_data[0] = va; e_full[0] = 1'b1; end
        if (eb) begin e_data[1] = vb; e_full[1] = 1'b1; end
        idle_irq();
        settle();
        check_all({tag, " R2 R4 R9 after strobe"});
    endtask

    task automatic do_read(input bit sa, input bit sb, input string tag);
        @(negedge clk);
        rd_n_i = 1'b0;
        sel_a_i = sa;
        sel_b_i = sb;
        if (sa) e_irq[0] = 1'b0;
        if (sb) e_irq[1] = 1'b0;
        settle();
        check_all({tag, " R5 mid-read"});
        rd_n_i = 1'b1;
        sel_a_i = 1'b0;
        sel_b_i = 1'b0;
        if (sa) e_full[0] = 1'b0;
        if (sb) e_full[1] = 1'b0;
        idle_irq();
        settle();
        check_all({tag, " R3 after read"});
    endtask

    task automatic do_bsr(input logic [2:0] bitn, input bit val, input string tag);
        @(negedge clk);
        bsr_we_i = 1'b1;
        bsr_bit_i = bitn;
        bsr_val_i = val;
        @(negedge clk);
        bsr_we_i = 1'b0;
        if (bitn == 3'd4) e_inte[0] = val;
        if (bitn == 3'd2) e_inte[1] = val;
        idle_irq();
        settle();
        check_all({tag, " R6 R7 after set/reset"});
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_2025));
        for (int c = 0; c < 2; c++) begin
            e_data[c] = '0; e_full[c] = 1'b0; e_irq[c] = 1'b0; e_inte[c] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R10 reset state");

        // R11 exact latency of the buffer-full flag
        pa_i = 8'hA5;
        stb_a_n_i = 1'b0;
        repeat (SYNC) @(negedge clk);
        cmp("R11 full not yet set", 32'(pc_o[5]), 32'd0);
        @(negedge clk);
        cmp("R11 full set on time", 32'(pc_o[5]), 32'd1);
        stb_a_n_i = 1'b1;
        pa_i = 8'h00;
        e_data[0] = 8'hA5;
        e_full[0] = 1'b1;
        settle();
        check_all("R1 R6 held byte, enable off");

        do_strobe(1'b1, 1'b0, 8'h3C, 8'h00, "R9 overwrite while full");
        do_bsr(3'd4, 1'b1, "R4 enable A raises request");
        do_read(1'b0, 1'b1, "R3 read of B leaves A");
        do_read(1'b1, 1'b0, "R5 read of A");
        do_bsr(3'd2, 1'b1, "R7 enable B");
        do_strobe(1'b0, 1'b1, 8'h00, 8'hC3, "R4 B request");
        do_bsr(3'd2, 1'b0, "R6 disable B withdraws");
        for (int b = 0; b < 8; b++) begin
            if (b != 2 && b != 4) do_bsr(3'(b), 1'b0, "R7 other bit ignored");
        end
        do_read(1'b1, 1'b1, "R3 read both");

        for (int i = 0; i < 250; i++) begin
            int op = int'($urandom_range(0, 3));
            case (op)
                0: do_strobe(1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), "R2 random strobe");
                1: do_read(1'($urandom), 1'($urandom), "R3 random read");
                2: do_bsr(3'($urandom), 1'($urandom), "R7 random set/reset");
                default: begin
                    settle();
                    check_all("R1 random idle");
                end
            endcase
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule